// File: doc/BRIEF.md
# I2C Host Format Command Sequencer

This block sits between a host-side queue of formatted entries and a bit-level I2C engine. Each entry holds one data byte and five flag bits. The sequencer pops one entry at a time and turns it into byte-level commands for the engine: START or repeated START, write a byte, read one byte with ACK or NACK, and STOP. During reads it counts the bytes and hands each received byte to a receive queue. After each written byte it checks the target's acknowledge.

An unexpected NACK halts the sequencer and latches a halt event. A NACK left uncleared for too long latches a second event. An engine command held up by a low SCL for too long latches a third event. Software clears these events bit by bit. Once all of them are clear, the sequencer sends STOP to release the bus and becomes idle again. Flag combinations that make no sense run as plain byte writes and raise a one-cycle error pulse.

Top module: `i2c_fseq`

## Requirements
- R1: An entry is popped (`fmt_pop_o` high in the cycle that `fmt_valid_i` is high) only while `host_en_i` is high, the sequencer is between entries, and no halt event is latched.
- R2: Flag bit 0 (start) issues command START (0) when no transaction is open, and repeated START (1) when one is open. A transaction opens when a start completes and closes when a STOP (5) completes.
- R3: With no read flag, the byte goes out as WRITE (2) on `cmd_byte_o`. The command stays valid and unchanged until `cmd_ready_i`. With flag bit 1 (stop), a STOP follows the written byte.
- R4: Flag bit 2 (read) makes the byte a count N of reads, where 0 means 256. Exactly N read commands are issued. Each byte returned by the engine shows on `rx_valid_o`/`rx_data_o` in its completion cycle.
- R5: Every read except the last uses RD_ACK (3). The last read uses RD_NACK (4), or RD_ACK when flag bit 3 (read_cont) is set. A stop flag then adds a STOP.
- R6: While `rx_full_i` is high, no read command is presented. The read resumes once the input falls.
- R7: A write completed with `nack_i` high sets halt event bit 0 and halts. Flag bit 4 (nakok) suppresses this for that entry. While halted, no entry is popped and no command is presented.
- R8: If event bit 0 stays set for `nack_lim_i` cycles (0 disables this), event bit 1 is set. If bit 0 is cleared in the last of those cycles, bit 1 is not set.
- R9: With `str_en_i` high, a command held for `str_lim_i` consecutive cycles with `scl_low_i` high and no `cmd_ready_i` is withdrawn, and event bit 2 is set.
- R10: Each `halt_clr_i` bit clears only its own event bit. A new event wins over its clear. When all bits are clear, a STOP is issued, and the sequencer then becomes idle.
- R11: An entry is illegal if it has read_cont without read, stop together with read and read_cont, or nakok together with read or read_cont. It runs as a byte write that keeps its start and stop but ignores read, read_cont and nakok. `err_o` pulses in its pop cycle.
- R12: `idle_o` is high only when the sequencer is between entries and no transaction is open. No command is presented while `idle_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_en_i | input | 1 | Enables popping of entries |
| fmt_valid_i | input | 1 | Format queue holds an entry |
| fmt_data_i | input | 8 | Entry byte (data or read count) |
| fmt_flags_i | input | 5 | Entry flags: [0] start, [1] stop, [2] read, [3] read_cont, [4] nakok |
| fmt_pop_o | output | 1 | Entry taken this cycle |
| err_o | output | 1 | Illegal flag combination on the popped entry |
| cmd_valid_o | output | 1 | Command presented to the bit engine |
| cmd_o | output | 3 | Command code 0..5 |
| cmd_byte_o | output | 8 | Byte to write |
| cmd_ready_i | input | 1 | Engine completes the presented command |
| nack_i | input | 1 | Target NACKed the written byte (valid with cmd_ready_i) |
| rd_data_i | input | 8 | Byte read by the engine (valid with cmd_ready_i) |
| scl_low_i | input | 1 | SCL currently held low by a target |
| rx_full_i | input | 1 | Receive queue full |
| rx_valid_o | output | 1 | Push received byte |
| rx_data_o | output | 8 | Received byte |
| nack_lim_i | input | 16 | NACK handling limit in cycles, 0 = off |
| str_en_i | input | 1 | Stretch timeout enable |
| str_lim_i | input | 16 | Stretch limit in cycles |
| halt_clr_i | input | 3 | Per-bit event clear |
| halt_evt_o | output | 3 | Latched events: [0] NACK, [1] NACK unhandled, [2] stretch timeout |
| halt_o | output | 1 | Any event latched |
| idle_o | output | 1 | No transaction in progress |

## Verification
Software's clear of the NACK event can land in the same cycle that the NACK handling timer expires. The bench sets up this case by raising the clear in exactly the limit-th cycle after the NACK becomes visible, and it requires that the unhandled-NACK bit then stays low. A second run clears one cycle later and requires that bit 1 is latched. The bench then clears bit 1 alone and requires that bit 0 and the halt stay in place with no STOP issued.

// File: rtl/i2c_fseq_pkg.sv
package i2c_fseq_pkg;
  typedef enum logic [2:0] {
    CMD_START   = 3'd0,
    CMD_RSTART  = 3'd1,
    CMD_WRITE   = 3'd2,
    CMD_RD_ACK  = 3'd3,
    CMD_RD_NACK = 3'd4,
    CMD_STOP    = 3'd5
  } cmd_e;

  typedef struct packed {
    logic nakok;
    logic rcont;
    logic rd;
    logic stop;
    logic start;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);
  localparam int EVT_W  = 3;
  localparam int EVT_NACK = 0;
  localparam int EVT_UNH  = 1;
  localparam int EVT_STR  = 2;
endpackage

// File: rtl/i2c_fseq_decode.sv
module i2c_fseq_decode
  import i2c_fseq_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  output flags_t            eff_o,
  output logic              illegal_o
);
  flags_t raw;
  assign raw = flags_t'(flags_i);

  assign illegal_o = (raw.rcont & ~raw.rd)
                   | (raw.stop & raw.rd & raw.rcont)
                   | (raw.nakok & (raw.rd | raw.rcont));

  always_comb begin
    eff_o = raw;
    if (illegal_o) begin
      eff_o.rd    = 1'b0;
      eff_o.rcont = 1'b0;
      eff_o.nakok = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_fseq_events.sv
module i2c_fseq_events
  import i2c_fseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_nack_i,
  input  logic             stretching_i,
  input  logic [CNT_W-1:0] nack_lim_i,
  input  logic             str_en_i,
  input  logic [CNT_W-1:0] str_lim_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] evt_o,
  output logic             abort_o
);
  logic [EVT_W-1:0] evt_q;
  logic [CNT_W-1:0] nack_t_q, str_t_q;
  logic             unh_fire, str_fire;

  assign unh_fire = evt_q[EVT_NACK] && (nack_lim_i != '0) && !clr_i[EVT_NACK]
                    && (nack_t_q == nack_lim_i - 1'b1);
  assign str_fire = stretching_i && str_en_i && (str_lim_i != '0)
                    && (str_t_q == str_lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= '0;
      nack_t_q <= '0;
      str_t_q  <= '0;
    end else begin
      evt_q <= (evt_q & ~clr_i) | {str_fire, unh_fire, set_nack_i};
      if (!evt_q[EVT_NACK] || clr_i[EVT_NACK]) nack_t_q <= '0;
      else if (nack_t_q != nack_lim_i)         nack_t_q <= nack_t_q + 1'b1;
      if (!stretching_i || str_fire) str_t_q <= '0;
      else                           str_t_q <= str_t_q + 1'b1;
    end
  end

  assign evt_o   = evt_q;
  assign abort_o = str_fire;

  p_evt_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(evt_q & ~clr_i) & ~evt_q) == '0));
  p_unh_needs_nack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[EVT_UNH]) |-> $past(evt_q[EVT_NACK]));
  p_str_needs_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_q[EVT_STR]) |-> $past(stretching_i && str_en_i));
endmodule

// File: rtl/i2c_fseq.sv
module i2c_fseq
  import i2c_fseq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_en_i,
  input  logic              fmt_valid_i,
  input  logic [BYTE_W-1:0] fmt_data_i,
  input  logic [FLAG_W-1:0] fmt_flags_i,
  output logic              fmt_pop_o,
  output logic              err_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_o,
  output logic [BYTE_W-1:0] cmd_byte_o,
  input  logic              cmd_ready_i,
  input  logic              nack_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic              scl_low_i,
  input  logic              rx_full_i,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic [CNT_W-1:0]  nack_lim_i,
  input  logic              str_en_i,
  input  logic [CNT_W-1:0]  str_lim_i,
  input  logic [EVT_W-1:0]  halt_clr_i,
  output logic [EVT_W-1:0]  halt_evt_o,
  output logic              halt_o,
  output logic              idle_o
);
  localparam int RD_W = BYTE_W + 1;
  localparam logic [RD_W-1:0] RD_MAX = RD_W'(1) << BYTE_W;
  localparam logic [RD_W-1:0] RD_ONE = RD_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_WRITE, S_READ, S_STOP, S_HALT} state_e;

  state_e            state_q;
  flags_t            fl_q, eff;
  logic [BYTE_W-1:0] byte_q;
  logic [RD_W-1:0]   rd_left_q;
  logic              in_txn_q;
  logic              illegal, done, stretching, set_nack, abort;
  cmd_e              cmd;

  i2c_fseq_decode u_dec (
    .flags_i   (fmt_flags_i),
    .eff_o     (eff),
    .illegal_o (illegal)
  );

  i2c_fseq_events #(.CNT_W(CNT_W)) u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_nack_i   (set_nack),
    .stretching_i (stretching),
    .nack_lim_i   (nack_lim_i),
    .str_en_i     (str_en_i),
    .str_lim_i    (str_lim_i),
    .clr_i        (halt_clr_i),
    .evt_o        (halt_evt_o),
    .abort_o      (abort)
  );

  assign halt_o    = |halt_evt_o;
  assign fmt_pop_o = host_en_i && fmt_valid_i && (state_q == S_IDLE) && !halt_o;
  assign err_o     = fmt_pop_o && illegal;
  assign idle_o    = (state_q == S_IDLE) && !in_txn_q;

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd         = CMD_WRITE;
    unique case (state_q)
      S_START: begin cmd_valid_o = 1'b1; cmd = in_txn_q ? CMD_RSTART : CMD_START; end
      S_WRITE: begin cmd_valid_o = 1'b1; cmd = CMD_WRITE; end
      S_READ:  begin
        cmd_valid_o = !rx_full_i;
        cmd = (rd_left_q == RD_ONE && !fl_q.rcont) ? CMD_RD_NACK : CMD_RD_ACK;
      end
      S_STOP:  begin cmd_valid_o = 1'b1; cmd = CMD_STOP; end
      default: ;
    endcase
  end

  assign cmd_o      = cmd;
  assign cmd_byte_o = byte_q;
  assign done       = cmd_valid_o && cmd_ready_i;
  assign stretching = cmd_valid_o && scl_low_i && !cmd_ready_i;
  assign rx_valid_o = done && (state_q == S_READ);
  assign rx_data_o  = rd_data_i;
  assign set_nack   = done && (state_q == S_WRITE) && nack_i && !fl_q.nakok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      fl_q      <= '0;
      byte_q    <= '0;
      rd_left_q <= '0;
      in_txn_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (fmt_pop_o) begin
          byte_q    <= fmt_data_i;
          fl_q      <= eff;
          rd_left_q <= (fmt_data_i == '0) ? RD_MAX : {1'b0, fmt_data_i};
          state_q   <= eff.start ? S_START : (eff.rd ? S_READ : S_WRITE);
        end
        S_START: if (abort) state_q <= S_HALT;
          else if (done) begin
            in_txn_q <= 1'b1;
            state_q  <= fl_q.rd ? S_READ : S_WRITE;
          end
        S_WRITE: if (abort) state_q <= S_HALT;
          else if (done) begin
            if (set_nack)       state_q <= S_HALT;
            else if (fl_q.stop) state_q <= S_STOP;
            else                state_q <= S_IDLE;
          end
        S_READ: if (abort) state_q <= S_HALT;
          else if (done) begin
            rd_left_q <= rd_left_q - 1'b1;
            if (rd_left_q == RD_ONE) state_q <= fl_q.stop ? S_STOP : S_IDLE;
          end
        S_STOP: if (abort) state_q <= S_HALT;
          else if (done) begin
            in_txn_q <= 1'b0;
            state_q  <= S_IDLE;
          end
        S_HALT: if (!halt_o) state_q <= S_STOP;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_cmd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && !abort && state_q != S_READ)
      |=> (cmd_valid_o && $stable(cmd_o) && $stable(cmd_byte_o)));
  p_rx_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_i |-> !(cmd_valid_o && (cmd_o == CMD_RD_ACK || cmd_o == CMD_RD_NACK)));
  p_halt_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!fmt_pop_o && !cmd_valid_o));
  p_err_on_pop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> fmt_pop_o);
  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !cmd_valid_o);
endmodule

// File: tb/i2c_fseq_test.sv
`timescale 1ns/1ps
module i2c_fseq_test;
  localparam logic [4:0] F_ST = 5'd1, F_SP = 5'd2, F_RD = 5'd4, F_RC = 5'd8, F_NK = 5'd16;
  localparam logic [2:0] C_ST = 3'd0, C_RS = 3'd1, C_WR = 3'd2, C_RA = 3'd3, C_RN = 3'd4, C_SP = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_en = 0, fmt_valid = 0, fmt_pop, err, cmd_valid, cmd_ready = 0, nack = 0;
  logic [7:0] fmt_data = 0, cmd_byte, rd_data = 0, rx_data;
  logic [4:0] fmt_flags = 0;
  logic [2:0] cmd, halt_clr = 0, halt_evt;
  logic scl_low = 0, rx_full = 0, rx_valid, str_en = 0, halt, idle;
  logic [15:0] nack_lim = 0, str_lim = 0;
  int nvec = 0, nerr = 0;

  always #2 clk = ~clk;

  i2c_fseq uut (
    .clk_i(clk), .rst_ni(rst_n), .host_en_i(host_en), .fmt_valid_i(fmt_valid),
    .fmt_data_i(fmt_data), .fmt_flags_i(fmt_flags), .fmt_pop_o(fmt_pop), .err_o(err),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_byte_o(cmd_byte), .cmd_ready_i(cmd_ready),
    .nack_i(nack), .rd_data_i(rd_data), .scl_low_i(scl_low), .rx_full_i(rx_full),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .nack_lim_i(nack_lim), .str_en_i(str_en),
    .str_lim_i(str_lim), .halt_clr_i(halt_clr), .halt_evt_o(halt_evt), .halt_o(halt),
    .idle_o(idle)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [4:0] f, output bit err_seen);
    bit got = 0;
    err_seen = 0;
    @(negedge clk);
    fmt_valid = 1; fmt_data = d; fmt_flags = f;
    for (int i = 0; i < 300; i++) begin
      #0.5;
      if (fmt_pop) begin got = 1; err_seen = err; end
      @(negedge clk);
      if (got) break;
    end
    fmt_valid = 0;
    chk(got, "R1 entry popped", int'(got), 1);
  endtask

  task automatic serve(input logic [2:0] ec, input logic [7:0] eb, input bit nk,
                       input logic [7:0] rd, input string tag);
    bit seen = 0;
    for (int i = 0; i < 300; i++) begin
      #0.5;
      if (cmd_valid) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, {tag, " cmd presented"}, int'(seen), 1);
    chk(cmd == ec, {tag, " cmd code"}, cmd, ec);
    if (ec == C_WR) chk(cmd_byte == eb, {tag, " write byte"}, cmd_byte, eb);
    cmd_ready = 1; nack = nk; rd_data = rd;
    #0.5;
    if (ec == C_RA || ec == C_RN)
      chk(rx_valid && rx_data == rd, {tag, " R4 rx push"}, rx_data, rd);
    @(negedge clk);
    cmd_ready = 0; nack = 0;
  endtask

  task automatic t_reset;
    fmt_valid = 1; fmt_flags = F_ST;
    repeat (3) @(negedge clk);
    #0.5;
    chk(!fmt_pop, "R1 no pop while disabled", fmt_pop, 0);
    chk(idle && !cmd_valid, "R12 reset idle", {idle, cmd_valid}, 2);
    chk(halt_evt == 0, "R10 reset events", halt_evt, 0);
    fmt_valid = 0; host_en = 1;
  endtask

  task automatic t_write;
    bit e;
    push(8'hA4, F_ST, e);
    chk(!e, "R11 legal no err", e, 0);
    serve(C_ST, 0, 0, 0, "R2 start");
    serve(C_WR, 8'hA4, 0, 0, "R3 write");
    #0.5 chk(!idle, "R12 open txn not idle", idle, 0);
    push(8'h11, F_SP, e);
    serve(C_WR, 8'h11, 0, 0, "R3 write");
    serve(C_SP, 0, 0, 0, "R3 stop");
    #0.5 chk(idle, "R12 idle after stop", idle, 1);
  endtask

  task automatic t_rstart_read;
    bit e;
    push(8'hA4, F_ST, e); serve(C_ST, 0, 0, 0, "R2"); serve(C_WR, 8'hA4, 0, 0, "R3");
    push(8'hA5, F_ST, e); serve(C_RS, 0, 0, 0, "R2 repeated start"); serve(C_WR, 8'hA5, 0, 0, "R3");
    push(8'd3, F_RD | F_SP, e);
    serve(C_RA, 0, 0, 8'hC1, "R5 ack");
    serve(C_RA, 0, 0, 8'hC2, "R5 ack");
    serve(C_RN, 0, 0, 8'hC3, "R5 final nack");
    serve(C_SP, 0, 0, 0, "R5 stop after read");
  endtask

  task automatic t_read_cont;
    bit e;
    push(8'd2, F_ST | F_RD | F_RC, e);
    chk(!e, "R11 legal rcont", e, 0);
    serve(C_ST, 0, 0, 0, "R2");
    serve(C_RA, 0, 0, 8'h21, "R5 cont ack");
    serve(C_RA, 0, 0, 8'h22, "R5 cont final ack");
    push(8'd1, F_RD | F_SP, e);
    serve(C_RN, 0, 0, 8'h23, "R5 final nack");
    serve(C_SP, 0, 0, 0, "R5 stop");
  endtask

  task automatic t_read_256;
    bit e;
    push(8'd0, F_ST | F_RD | F_SP, e);
    serve(C_ST, 0, 0, 0, "R4");
    for (int i = 0; i < 255; i++) serve(C_RA, 0, 0, 8'(i), "R4 zero count");
    serve(C_RN, 0, 0, 8'h5A, "R4 256th nack");
    serve(C_SP, 0, 0, 0, "R4 stop");
  endtask

  task automatic t_rx_stall;
    bit e;
    rx_full = 1;
    push(8'd1, F_ST | F_RD | F_SP, e);
    serve(C_ST, 0, 0, 0, "R6");
    for (int i = 0; i < 5; i++) begin
      #0.5 chk(!cmd_valid, "R6 read stalled", cmd_valid, 0);
      @(negedge clk);
    end
    rx_full = 0;
    serve(C_RN, 0, 0, 8'h77, "R6 resumed");
    serve(C_SP, 0, 0, 0, "R6");
  endtask

  task automatic t_nack_halt;
    bit e;
    nack_lim = 0;
    push(8'h50, F_ST, e); serve(C_ST, 0, 0, 0, "R7"); serve(C_WR, 8'h50, 1, 0, "R7 nacked");
    #0.5 chk(halt_evt == 3'b001 && halt, "R7 nack event", halt_evt, 1);
    @(negedge clk); fmt_valid = 1; fmt_flags = F_ST;
    for (int i = 0; i < 4; i++) begin
      #0.5 chk(!fmt_pop && !cmd_valid, "R7 halted quiet", {fmt_pop, cmd_valid}, 0);
      @(negedge clk);
    end
    fmt_valid = 0; halt_clr = 3'b001;
    @(negedge clk); halt_clr = 0;
    serve(C_SP, 0, 0, 0, "R10 stop after clear");
    #0.5 chk(idle && halt_evt == 0, "R10 idle after release", halt_evt, 0);
  endtask

  task automatic t_nakok;
    bit e;
    push(8'h70, F_ST | F_NK, e); chk(!e, "R11 legal nakok", e, 0);
    serve(C_ST, 0, 0, 0, "R7"); serve(C_WR, 8'h70, 1, 0, "R7 nakok");
    #0.5 chk(!halt && halt_evt == 0, "R7 nakok no halt", halt_evt, 0);
    push(8'h71, F_SP, e); serve(C_WR, 8'h71, 0, 0, "R7"); serve(C_SP, 0, 0, 0, "R7");
  endtask

  task automatic t_unhandled;
    bit e;
    nack_lim = 16'd8;
    // clear in the expiry cycle: unhandled must not latch
    push(8'h52, F_ST, e); serve(C_ST, 0, 0, 0, "R8"); serve(C_WR, 8'h52, 1, 0, "R8");
    repeat (7) @(negedge clk);
    halt_clr = 3'b001;
    @(negedge clk); halt_clr = 0;
    #0.5 chk(halt_evt == 0, "R8 cleared in time", halt_evt, 0);
    serve(C_SP, 0, 0, 0, "R8");
    // clear one cycle late: unhandled latches
    push(8'h53, F_ST, e); serve(C_ST, 0, 0, 0, "R8"); serve(C_WR, 8'h53, 1, 0, "R8");
    repeat (8) @(negedge clk);
    #0.5 chk(halt_evt == 3'b011, "R8 unhandled latched", halt_evt, 3);
    @(negedge clk); halt_clr = 3'b010;
    @(negedge clk); halt_clr = 0;
    #0.5 chk(halt_evt == 3'b001 && halt && !cmd_valid, "R10 selective clear", halt_evt, 1);
    @(negedge clk); halt_clr = 3'b001;
    @(negedge clk); halt_clr = 0;
    serve(C_SP, 0, 0, 0, "R10 stop");
    nack_lim = 0;
  endtask

  task automatic t_stretch;
    bit e;
    str_en = 1; str_lim = 16'd5;
    push(8'h60, F_ST, e);
    for (int i = 0; i < 50; i++) begin
      #0.5;
      if (cmd_valid) break;
      @(negedge clk);
    end
    scl_low = 1;
    repeat (4) @(negedge clk);
    #0.5 chk(cmd_valid && halt_evt == 0, "R9 before limit", halt_evt, 0);
    @(negedge clk);
    #0.5 chk(halt_evt == 3'b100 && !cmd_valid, "R9 stretch abort", halt_evt, 4);
    scl_low = 0; str_en = 0;
    @(negedge clk); halt_clr = 3'b100;
    @(negedge clk); halt_clr = 0;
    serve(C_SP, 0, 0, 0, "R9 stop");
    #0.5 chk(idle, "R12 idle after abort", idle, 1);
  endtask

  task automatic t_illegal;
    bit e;
    push(8'h33, F_ST | F_RC, e); chk(e, "R11 rcont without read", e, 1);
    serve(C_ST, 0, 0, 0, "R11"); serve(C_WR, 8'h33, 0, 0, "R11 as write");
    push(8'h44, F_RD | F_NK, e); chk(e, "R11 nakok with read", e, 1);
    serve(C_WR, 8'h44, 0, 0, "R11 as write");
    push(8'h02, F_RD | F_RC | F_SP, e); chk(e, "R11 stop read rcont", e, 1);
    serve(C_WR, 8'h02, 0, 0, "R11 as write");
    serve(C_SP, 0, 0, 0, "R11 stop kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_write;
    t_rstart_read;
    t_read_cont;
    t_read_256;
    t_rx_stall;
    t_nack_halt;
    t_nakok;
    t_unhandled;
    t_stretch;
    t_illegal;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule